// File: doc/BRIEF.md
# Single-Level Interrupt Controller with Return-Stack Guard

This block collects interrupt requests for a small 8-bit processor core. One external event input and a parameterized number of timer/event-counter overflow inputs each set a pending flag. A single control register holds these flags, one enable bit per source and a global enable bit. Software reads and writes that register over a simple register bus. When the global enable is on, at least one enabled source is pending and the core's return stack has room, the block raises a request and presents the vector index of the winning source.

When the core acknowledges a raised request, the interrupt is taken in that cycle. The block then clears the global enable, so no second interrupt can cut in, and clears the pending flag of the served source. Flags of other sources stay pending. A service routine that wants nesting sets the global enable again. A separate wake output tells the halt logic that an enabled source is pending. That output ignores the global enable and the stack state.

Top module: `irq_unit`

## Requirements
- R1: After reset the control register reads 0x00, and irq_req, irq_taken and wake are all 0.
- R2: A cycle with an event input high sets that source's pending flag on the next clock edge. The flag stays set while the global enable is 0. Source 0 is the external input and source k+1 is timer input k.
- R3: irq_req is 1 exactly when the global enable is 1, some source has both its enable and its flag at 1, and stk_full is 0.
- R4: While stk_full is 1, irq_req is 0 and core_ack changes neither the control register nor irq_taken.
- R5: irq_vec is the index of the lowest-numbered source whose enable and flag are both 1. Source 0 has the highest priority.
- R6: irq_taken is 1 in a cycle where core_ack and irq_req are both 1. On the following edge the global enable is cleared and the served source's flag is cleared, and all other flags are kept.
- R7: If an event on the served source arrives in the same cycle the interrupt is taken, that source's flag remains set.
- R8: wake is 1 exactly when some source has both its enable and its flag at 1. It does not depend on the global enable or on stk_full.
- R9: With the default of 2 timers, the control register sits at bus address 0x0B. Its layout is: bit 0 global enable, bits 1..3 enables of sources 0..2, bits 4..6 flags of sources 0..2, and bit 7 reads as 0. Any other address reads 0x00, and writes to any other address have no effect.
- R10: A register write can set or clear any flag or enable. When a write lands in the same cycle as a take, the hardware clear of the global enable and of the served flag overrides the written value.
- R11: Nesting: after a take, writing the global enable to 1 again lets the next pending enabled source be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_evt | input | 1 | External interrupt event, one pulse per cycle high |
| tmr_evt | input | N_TMR | Timer/event-counter overflow events |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | DATA_W | Register bus write data |
| bus_rdata | output | DATA_W | Register bus read data (combinational) |
| stk_full | input | 1 | Return stack of the core is full |
| core_ack | input | 1 | Core accepts the pending request this cycle |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Index of the winning source |
| irq_taken | output | 1 | Interrupt taken this cycle |
| wake | output | 1 | Wake request for the halted state |

## Verification
Three writers can reach one pending flag in the same cycle: the source's event input, the hardware clear from a take, and a software register write. The bench makes these collide in two ways. In the first, a timer event is pulsed in the very cycle that timer is served. In the second, a full register write goes out in the cycle of a take. In each case the bench reads the register back and compares it with the precedence set out in R7 and R10: the event wins over the take, and the take wins over the write. Each acknowledge also queues the vector that the priority rule predicts. The monitor then matches every irq_taken pulse against that queue.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned MAX_SRC = 16;

  // Index of the lowest set bit; returns 0 when no bit is set.
  function automatic int unsigned lowest_set(input logic [MAX_SRC-1:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = MAX_SRC - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Next state of one pending flag: write first, then take clear, then event set.
  function automatic logic flag_next(input logic cur, input logic wr, input logic wbit,
                                     input logic clr, input logic set);
    logic n;
    n = cur;
    if (wr)  n = wbit;
    if (clr) n = 1'b0;
    if (set) n = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            wr_hit,
  input  logic [NSRC-1:0] wr_flags,
  input  logic [NSRC-1:0] grant,
  output logic [NSRC-1:0] flags
);

  logic [NSRC-1:0] flags_nxt;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      always_comb begin
        flags_nxt[g] = flag_next(flags[g], wr_hit, wr_flags[g], grant[g], evt[g]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[g] <= 1'b0;
        else        flags[g] <= flags_nxt[g];
      end

      AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt[g] |=> flags[g]); // R2
      AST_TAKE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[g] && !evt[g]) |=> !flags[g]); // R6
    end
  endgenerate

endmodule

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg #(
  parameter int unsigned NSRC   = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  input  logic [NSRC-1:0]   flags,
  output logic              master,
  output logic [NSRC-1:0]   enables,
  output logic [NSRC-1:0]   wr_flags,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned EN_LSB = 1;
  localparam int unsigned FL_LSB = EN_LSB + NSRC;
  localparam int unsigned USED   = FL_LSB + NSRC;

  logic master_nxt;

  assign wr_flags = wdata[FL_LSB +: NSRC];

  always_comb begin
    master_nxt = master;
    if (wr_hit) master_nxt = wdata[0];
    if (take)   master_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master  <= 1'b0;
      enables <= '0;
    end else begin
      master <= master_nxt;
      if (wr_hit) enables <= wdata[EN_LSB +: NSRC];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      rdata[0]                = master;
      rdata[EN_LSB +: NSRC]   = enables;
      rdata[FL_LSB +: NSRC]   = flags;
    end
  end

  generate
    if (USED < DATA_W) begin : g_pad
      AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:USED] == '0); // R9
    end
  endgenerate

  AST_TAKE_CLEARS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !master); // R6
  AST_NO_HIT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !take) |=> $stable(enables)); // R9

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC  = 3,
  parameter int unsigned VEC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  input  logic             master,
  input  logic             stk_full,
  input  logic             ack,
  output logic             req,
  output logic             take,
  output logic [VEC_W-1:0] vec,
  output logic [NSRC-1:0]  grant
);

  logic [MAX_SRC-1:0] pend_wide;
  int unsigned        win;

  always_comb begin
    pend_wide = '0;
    pend_wide[NSRC-1:0] = pend;
    win = lowest_set(pend_wide);
  end

  assign vec   = VEC_W'(win);
  assign req   = master && (|pend) && !stk_full;
  assign take  = req && ack;

  always_comb begin
    grant = '0;
    if (take) grant[vec] = 1'b1;
  end

  AST_FULL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> (!req && grant == '0)); // R4
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~pend) == '0)); // R5
  AST_REQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> master); // R3

endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int unsigned N_TMR     = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h0B,
  parameter int unsigned NSRC      = N_TMR + 1,
  parameter int unsigned VEC_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_evt,
  input  logic [N_TMR-1:0]  tmr_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              stk_full,
  input  logic              core_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              irq_taken,
  output logic              wake
);

  // Named internal events for checking.
  logic              rd_hit;
  logic              wr_hit;
  logic [NSRC-1:0]   evt_all;
  logic [NSRC-1:0]   flags;
  logic [NSRC-1:0]   enables;
  logic [NSRC-1:0]   wr_flags;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   grant;
  logic              master;
  logic              take;

  assign rd_hit  = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign wr_hit  = rd_hit && bus_wr;
  assign evt_all = {tmr_evt, ext_evt};
  assign pend    = flags & enables;

  irqc_ctrl_reg #(.NSRC(NSRC), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit), .wdata(bus_wdata),
    .take(take), .flags(flags), .master(master), .enables(enables),
    .wr_flags(wr_flags), .rdata(bus_rdata)
  );

  irqc_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_all), .wr_hit(wr_hit),
    .wr_flags(wr_flags), .grant(grant), .flags(flags)
  );

  irqc_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .master(master), .stk_full(stk_full),
    .ack(core_ack), .req(irq_req), .take(take), .vec(irq_vec), .grant(grant)
  );

  assign irq_taken = take;
  assign wake      = |pend;

  AST_WAKE_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake); // R8
  AST_FULL_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_full && !wr_hit && evt_all == '0) |=> ($stable(flags) && $stable(master))); // R4
  AST_TAKEN_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> (core_ack && !stk_full)); // R6

endmodule

// File: tb/test_irq_unit.sv
module test_irq_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_evt = 1'b0;
  logic [1:0] tmr_evt = '0;
  logic [7:0] bus_addr = 8'h0B;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       stk_full = 1'b0;
  logic       core_ack = 1'b0;
  logic       irq_req;
  logic [1:0] irq_vec;
  logic       irq_taken;
  logic       wake;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  irq_unit i_irq_unit (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .tmr_evt(tmr_evt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stk_full(stk_full), .core_ack(core_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_taken(irq_taken), .wake(wake)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every taken pulse must match the next predicted vector.
  always @(negedge clk) begin
    if (rst_n && irq_taken) begin
      if (exp_q.size() == 0) check("R6 unexpected take", 1, 0);
      else check("R5 taken vector", irq_vec, exp_q.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_addr = 8'h0B;
  endtask

  function automatic int rd(input logic [7:0] a);
    return 0;
  endfunction

  task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
    bus_addr = 8'h0B;
  endtask

  // Driver: acknowledge and predict the vector the priority rule selects.
  task automatic ack_pred(input int vec_exp);
    exp_q.push_back(vec_exp);
    core_ack = 1'b1;
    tick();
    core_ack = 1'b0;
  endtask

  initial begin
    #200000;
    check("watchdog", 1, 0);
    done = 1;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    read_chk("R1 reset reg", 8'h0B, 8'h00);
    check("R1 reset req", irq_req, 0);
    check("R1 reset wake", wake, 0);
    check("R1 reset taken", irq_taken, 0);
    rst_n = 1'b1;
    tick();

    ext_evt = 1'b1; tick(); ext_evt = 1'b0;
    tick();
    read_chk("R2 ext flag pending", 8'h0B, 8'h10);
    check("R3 no req without master", irq_req, 0);
    check("R8 no wake without enable", wake, 0);

    wr(8'h0B, 8'h12);
    check("R8 wake ignores master", wake, 1);
    check("R3 req off master 0", irq_req, 0);
    wr(8'h0B, 8'h13);
    check("R3 req on", irq_req, 1);
    check("R5 vec ext", irq_vec, 0);

    stk_full = 1'b1; #1;
    check("R4 req blocked", irq_req, 0);
    check("R8 wake ignores stack", wake, 1);
    core_ack = 1'b1; tick(); core_ack = 1'b0;
    read_chk("R4 ack ignored when full", 8'h0B, 8'h13);
    stk_full = 1'b0;

    ack_pred(0);
    read_chk("R6 master and flag cleared", 8'h0B, 8'h02);

    ext_evt = 1'b1; tmr_evt = 2'b11; tick(); ext_evt = 1'b0; tmr_evt = 2'b00;
    read_chk("R2 all flags", 8'h0B, 8'h72);
    wr(8'h0B, 8'h7F);
    check("R5 ext first", irq_vec, 0);
    ack_pred(0);
    read_chk("R6 others kept", 8'h0B, 8'h6E);
    check("R11 no req after take", irq_req, 0);
    wr(8'h0B, 8'h6F);
    check("R11 nest vec timer0", irq_vec, 1);
    ack_pred(1);
    read_chk("R11 timer0 served", 8'h0B, 8'h4E);
    wr(8'h0B, 8'h4F);
    check("R5 vec timer1", irq_vec, 2);
    tmr_evt = 2'b10;
    ack_pred(2);
    tmr_evt = 2'b00;
    read_chk("R7 event in take cycle keeps flag", 8'h0B, 8'h4E);

    wr(8'h0B, 8'h4F);
    exp_q.push_back(2);
    bus_addr = 8'h0B; bus_wdata = 8'h7F; bus_wr = 1'b1; core_ack = 1'b1;
    tick();
    bus_wr = 1'b0; core_ack = 1'b0;
    read_chk("R10 take overrides write", 8'h0B, 8'h3E);

    wr(8'h0C, 8'hFF);
    read_chk("R9 other addr reads 0", 8'h0C, 8'h00);
    read_chk("R9 other addr write ignored", 8'h0B, 8'h3E);
    wr(8'h0B, 8'hFF);
    read_chk("R9 bit7 reads 0", 8'h0B, 8'h7F);

    wr(8'h0B, 8'h70);
    check("R8 no wake flags only", wake, 0);
    check("R10 software clear enables req", irq_req, 0);
    wr(8'h0B, 8'h25);
    check("R5 only timer0 enabled", irq_vec, 1);
    check("R3 req timer0", irq_req, 1);

    wr(8'h0B, 8'h0E);
    core_ack = 1'b1; tick(); core_ack = 1'b0;
    read_chk("R6 ack without req no effect", 8'h0B, 8'h0E);

    tick();
    check("R5 all predicted takes seen", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule